// File: doc/BRIEF.md
# Interrupt Steering Aggregator

The block gathers a wide set of level-sensitive interrupt lines, sixty-four for every configured group, and folds them into one interrupt line toward a chosen output channel. Software reaches it through a plain 32-bit register port. It uses that port for three tasks: to enable individual sources, to force sources pending for test, and to find which enabled sources are pending.

Each source input is registered once before it is used. A source's pending state is its registered level or its software-forced bit, gated by its enable bit. The output line of every selected channel is the OR of all pending sources. A master disable bit can hold every channel line low. A master status bit shows the OR before that disable is applied.

The register map grows with the group parameter, so every bank's base offset moves with it. Within a bank, the 32-bit words are numbered in reverse order of source number: source 0 lives in the highest-numbered word.

Top module: `intsteer_agg`

## Requirements
- R1: With G groups there are 64·G sources and each bank holds 2·G words. Source k sits in word (2·G − 1 − k/32), at bit k mod 32, in the mask, force and status banks alike.
- R2: Byte offsets of the registers:
  - channel select: 0x0
  - mask word n: 0x4 + 4n
  - force word n: 8G + 0x4 + 4n
  - status word n: 16G + 0x4 + 4n
  - master disable: 24G + 0x4
  - master status: 24G + 0x8
- R3: Mask and force words read back exactly what was last written. The channel select reads back its low NCHAN bits, and its other bits read as zero. The master disable reads back bit 0, and its other bits read as zero.
- R4: A status bit is 1 when the source's registered input level is 1 and its mask bit is 1. An input is seen one clock after it is applied, and stays reported for as long as it is held.
- R5: A force bit set to 1 makes its source pending while the mask bit is 1. It has no effect while the mask bit is 0.
- R6: Output line chan_irq[i] is 1 exactly when three conditions hold: channel select bit i is 1, at least one status bit is 1, and master disable bit 0 is 0. With no channel bit set, every line stays 0.
- R7: Master status bit 0 is the OR of all status bits and ignores the master disable. Its other bits read as zero.
- R8: Reset clears all mask, force, channel-select and master-disable bits, so every read returns zero and every output line is 0.
- R9: A read at an unmapped or misaligned offset returns zero. A write there, or to the read-only status and master-status offsets, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 64·GROUPS | Level-sensitive interrupt inputs, bit k = source k |
| chan_irq | output | NCHAN | Aggregated interrupt, one line per channel |

## Verification
The assertions assume that bus_we, bus_addr and bus_wdata are steady around the rising edge. They also assume that src_in is already synchronous to clk, because the block registers it only once. The bench changes every input on the falling edge and samples outputs two time units later. In the random phase it writes arbitrary 32-bit patterns, including channel-select values that are not one-hot, so the assertions on unselected channels and on the master disable are exercised beyond the intended one-hot use.

// File: rtl/intsteer_pkg.sv
package intsteer_pkg;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_MASK, RG_FORCE, RG_STAT, RG_MDIS, RG_MSTAT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [15:0] idx;
  } reg_hit_t;

  // Lowest source number held by bank word w (words run in reverse order).
  function automatic int unsigned src_base(input int unsigned w, input int unsigned groups);
    return 32 * (2 * groups - 1 - w);
  endfunction

  // Map a byte offset to a register kind and word index.
  function automatic reg_hit_t decode_addr(input int unsigned a, input int unsigned groups);
    reg_hit_t    h;
    int unsigned stride;
    stride = 8 * groups;
    h.kind = RG_NONE;
    h.idx  = '0;
    if (a % 4 == 0) begin
      if (a == 0) h.kind = RG_CTRL;
      else if (a < 4 + stride) begin
        h.kind = RG_MASK;  h.idx = 16'((a - 4) / 4);
      end else if (a < 4 + 2 * stride) begin
        h.kind = RG_FORCE; h.idx = 16'((a - 4 - stride) / 4);
      end else if (a < 4 + 3 * stride) begin
        h.kind = RG_STAT;  h.idx = 16'((a - 4 - 2 * stride) / 4);
      end else if (a == 3 * stride + 4) h.kind = RG_MDIS;
      else if (a == 3 * stride + 8) h.kind = RG_MSTAT;
    end
    return h;
  endfunction

endpackage

// File: rtl/intsteer_regs.sv
module intsteer_regs
  import intsteer_pkg::*;
#(
  parameter int GROUPS = 1,
  parameter int NCHAN  = 4,
  parameter int ADDR_W = 7,
  localparam int NWORD = 2 * GROUPS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NWORD*32-1:0]   status_flat,
  input  logic                  irq_any,
  output logic [NWORD*32-1:0]   mask_flat,
  output logic [NWORD*32-1:0]   force_flat,
  output logic [NCHAN-1:0]      ctrl_q,
  output logic                  mdis_q,
  output logic                  acc_unmapped
);

  reg_hit_t    hit;
  logic [31:0] mask_q  [NWORD];
  logic [31:0] force_q [NWORD];

  assign hit          = decode_addr(32'(bus_addr), GROUPS);
  assign acc_unmapped = (hit.kind == RG_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mdis_q <= 1'b0;
    end else if (bus_we) begin
      if (hit.kind == RG_CTRL) ctrl_q <= bus_wdata[NCHAN-1:0];
      if (hit.kind == RG_MDIS) mdis_q <= bus_wdata[0];
    end
  end

  for (genvar n = 0; n < NWORD; n++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[n]  <= '0;
        force_q[n] <= '0;
      end else if (bus_we && hit.idx == 16'(n)) begin
        if (hit.kind == RG_MASK)  mask_q[n]  <= bus_wdata;
        if (hit.kind == RG_FORCE) force_q[n] <= bus_wdata;
      end
    end
    assign mask_flat[n*32 +: 32]  = mask_q[n];
    assign force_flat[n*32 +: 32] = force_q[n];
  end

  always_comb begin
    bus_rdata = '0;
    case (hit.kind)
      RG_CTRL:  bus_rdata[NCHAN-1:0] = ctrl_q;
      RG_MDIS:  bus_rdata[0] = mdis_q;
      RG_MSTAT: bus_rdata[0] = irq_any;
      RG_MASK, RG_FORCE, RG_STAT: begin
        for (int n = 0; n < NWORD; n++) begin
          if (hit.idx == 16'(n)) begin
            if (hit.kind == RG_MASK)       bus_rdata = mask_q[n];
            else if (hit.kind == RG_FORCE) bus_rdata = force_q[n];
            else                           bus_rdata = status_flat[n*32 +: 32];
          end
        end
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/intsteer_status.sv
module intsteer_status
  import intsteer_pkg::*;
#(
  parameter int GROUPS = 1,
  localparam int NWORD = 2 * GROUPS,
  localparam int NSRC  = 64 * GROUPS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     src_in,
  input  logic [NWORD*32-1:0] mask_flat,
  input  logic [NWORD*32-1:0] force_flat,
  output logic [NWORD*32-1:0] status_flat,
  output logic                irq_any
);

  logic [NSRC-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_in;
  end

  for (genvar n = 0; n < NWORD; n++) begin : g_stat
    localparam int unsigned BASE = src_base(n, GROUPS);
    assign status_flat[n*32 +: 32] =
      (src_q[BASE +: 32] | force_flat[n*32 +: 32]) & mask_flat[n*32 +: 32];
  end

  assign irq_any = |status_flat;

endmodule

// File: rtl/intsteer_chan.sv
module intsteer_chan #(
  parameter int NCHAN = 4
) (
  input  logic [NCHAN-1:0] ctrl_q,
  input  logic             mdis_q,
  input  logic             irq_any,
  output logic [NCHAN-1:0] chan_irq
);

  logic fire;
  assign fire = irq_any & ~mdis_q;

  for (genvar i = 0; i < NCHAN; i++) begin : g_ch
    assign chan_irq[i] = ctrl_q[i] & fire;
  end

endmodule

// File: rtl/intsteer_agg.sv
module intsteer_agg #(
  parameter int GROUPS = 1,
  parameter int NCHAN  = 4,
  parameter int ADDR_W = $clog2(24 * GROUPS + 16) + 1,
  localparam int NWORD = 2 * GROUPS,
  localparam int NSRC  = 64 * GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic [NCHAN-1:0]  chan_irq
);

  logic [NWORD*32-1:0] mask_flat;
  logic [NWORD*32-1:0] force_flat;
  logic [NWORD*32-1:0] status_flat;
  logic [NCHAN-1:0]    ctrl_q;
  logic                mdis_q;
  logic                irq_any;
  logic                acc_unmapped;

  intsteer_regs #(.GROUPS(GROUPS), .NCHAN(NCHAN), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_flat(status_flat),
    .irq_any(irq_any), .mask_flat(mask_flat), .force_flat(force_flat),
    .ctrl_q(ctrl_q), .mdis_q(mdis_q), .acc_unmapped(acc_unmapped)
  );

  intsteer_status #(.GROUPS(GROUPS)) stat_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .mask_flat(mask_flat),
    .force_flat(force_flat), .status_flat(status_flat), .irq_any(irq_any)
  );

  intsteer_chan #(.NCHAN(NCHAN)) chan_i (
    .ctrl_q(ctrl_q), .mdis_q(mdis_q), .irq_any(irq_any), .chan_irq(chan_irq)
  );

endmodule

// File: rtl/intsteer_agg_chk.sv
module intsteer_agg_chk #(
  parameter int NCHAN = 4,
  parameter int NWORD = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [NCHAN-1:0]    chan_irq,
  input logic [NCHAN-1:0]    ctrl_q,
  input logic                mdis_q,
  input logic                irq_any,
  input logic                acc_unmapped,
  input logic [NWORD*32-1:0] mask_flat,
  input logic [NWORD*32-1:0] force_flat,
  input logic [NWORD*32-1:0] status_flat
);

  p_chan_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq & ~ctrl_q) == '0);

  p_master_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mdis_q |-> chan_irq == '0);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_any |-> chan_irq == '0);

  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_flat == '0) |-> (status_flat == '0 && !irq_any));

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_flat == '0 && force_flat == '0 && ctrl_q == '0 && !mdis_q));

  p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && acc_unmapped) |=> ($stable(mask_flat) && $stable(force_flat)
                                  && $stable(ctrl_q) && $stable(mdis_q)));

endmodule

bind intsteer_agg intsteer_agg_chk #(.NCHAN(NCHAN), .NWORD(NWORD)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .chan_irq(chan_irq),
  .ctrl_q(ctrl_q), .mdis_q(mdis_q), .irq_any(irq_any),
  .acc_unmapped(acc_unmapped), .mask_flat(mask_flat),
  .force_flat(force_flat), .status_flat(status_flat)
);

// File: tb/intsteer_agg_tb.sv
module intsteer_agg_tb_top;
  localparam int G    = 1;
  localparam int W    = 2 * G;
  localparam int NSRC = 64 * G;
  localparam int NCH  = 4;
  localparam int AW   = $clog2(24 * G + 16) + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NSRC-1:0] src_in = '0;
  logic [NCH-1:0]  chan_irq;

  intsteer_agg #(.GROUPS(G), .NCHAN(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .chan_irq(chan_irq)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0]     mask_m  [W];
  logic [31:0]     force_m [W];
  logic [NCH-1:0]  ctrl_m;
  logic            mdis_m;
  logic [NSRC-1:0] src_m;

  function automatic int a_mask(int n);  return 4 + 4 * n;          endfunction
  function automatic int a_force(int n); return 8 * G + 4 + 4 * n;  endfunction
  function automatic int a_stat(int n);  return 16 * G + 4 + 4 * n; endfunction
  function automatic int a_mdis();       return 24 * G + 4;         endfunction
  function automatic int a_mstat();      return 24 * G + 8;         endfunction

  // Expected status word, walking sources and placing each one by R1.
  function automatic logic [31:0] exp_stat(int w);
    logic [31:0] r = '0;
    for (int k = 0; k < NSRC; k++) begin
      int wi = 2 * G - 1 - k / 32;
      int bi = k % 32;
      if (wi == w && (src_m[k] || force_m[wi][bi]) && mask_m[wi][bi]) r[bi] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic exp_any();
    logic a = 1'b0;
    for (int w = 0; w < W; w++) a |= (exp_stat(w) != 0);
    return a;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < W; n++) begin mask_m[n] = '0; force_m[n] = '0; end
    ctrl_m = '0; mdis_m = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = AW'(a);
    #2 d = bus_rdata;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    for (int n = 0; n < W; n++) begin
      if (a == a_mask(n))  mask_m[n]  = d;
      if (a == a_force(n)) force_m[n] = d;
    end
    if (a == 0)        ctrl_m = d[NCH-1:0];
    if (a == a_mdis()) mdis_m = d[0];
  endtask

  task automatic drive_src(logic [NSRC-1:0] v);
    @(negedge clk);
    src_in = v; src_m = v;
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [31:0] d;
    logic [NCH-1:0] ec;
    for (int n = 0; n < W; n++) begin
      rd(a_stat(n), d);  chk("R4 status word", d, exp_stat(n));
      rd(a_mask(n), d);  chk("R3 mask readback", d, mask_m[n]);
      rd(a_force(n), d); chk("R3 force readback", d, force_m[n]);
    end
    rd(a_mstat(), d); chk("R7 master status", d, {31'b0, exp_any()});
    rd(0, d);         chk("R3 channel readback", d, 32'(ctrl_m));
    ec = (exp_any() && !mdis_m) ? ctrl_m : '0;
    chk("R6 channel lines", 32'(chan_irq), 32'(ec));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED1234));
    model_reset();
    src_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: reset state
    check_all();
    chk("R8 chan after reset", 32'(chan_irq), 32'h0);

    // R1/R2: source 0 lands in the highest word, source 32 and 63 in word 0
    wr(a_mask(0), 32'hFFFF_FFFF);
    wr(a_mask(1), 32'hFFFF_FFFF);
    wr(0, 32'h1);
    drive_src(64'h1);
    rd(a_stat(1), d); chk("R1 source 0 -> word 1 bit 0", d, 32'h1);
    rd(a_stat(0), d); chk("R1 word 0 empty", d, 32'h0);
    chk("R6 channel 0 fires", 32'(chan_irq), 32'h1);
    drive_src(64'h8000_0001_0000_0000);
    rd(a_stat(0), d); chk("R1 sources 32,63 -> word 0", d, 32'h8000_0001);
    rd(a_stat(1), d); chk("R4 released level clears", d, 32'h0);

    // R4: the level is seen one clock after it is applied and held
    @(negedge clk); src_in = 64'h10; src_m = 64'h10;
    @(posedge clk); #2;
    rd(a_stat(1), d); chk("R4 level seen next clock", d, 32'h10);
    repeat (5) @(posedge clk);
    rd(a_stat(1), d); chk("R4 level held", d, 32'h10);
    drive_src('0);

    // R5: forcing, with and without the mask bit
    wr(a_force(1), 32'h4);
    rd(a_stat(1), d); chk("R5 forced pending", d, 32'h4);
    wr(a_mask(1), 32'hFFFF_FFFB);
    rd(a_stat(1), d); chk("R5 force masked off", d, 32'h0);
    wr(a_force(1), 32'h0);
    wr(a_mask(1), 32'hFFFF_FFFF);

    // R6/R7: master disable and empty channel select
    drive_src(64'h2);
    wr(a_mdis(), 32'h1);
    chk("R6 disabled line low", 32'(chan_irq), 32'h0);
    rd(a_mstat(), d); chk("R7 mstat ignores disable", d, 32'h1);
    rd(a_mdis(), d);  chk("R3 mdis readback", d, 32'h1);
    wr(a_mdis(), 32'h0);
    wr(0, 32'hFFFF_FFF0);
    chk("R6 no channel selected", 32'(chan_irq), 32'h0);
    rd(0, d); chk("R3 ctrl upper bits zero", d, 32'h0);
    wr(0, 32'h8);
    chk("R6 channel 3 fires", 32'(chan_irq), 32'h8);

    // R9: unmapped, misaligned and read-only targets
    @(negedge clk); bus_we = 1'b1; bus_addr = AW'(24 * G + 12); bus_wdata = '0;
    @(negedge clk); bus_addr = AW'(5);
    @(negedge clk); bus_addr = AW'(a_stat(0));
    @(negedge clk); bus_addr = AW'(a_mstat());
    @(negedge clk); bus_we = 1'b0;
    rd(24 * G + 12, d); chk("R9 unmapped reads zero", d, 32'h0);
    rd(a_mask(0) + 1, d); chk("R9 misaligned reads zero", d, 32'h0);
    check_all();

    // Random phase
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 7)
        0: wr(a_mask($urandom % W), $urandom & $urandom);
        1: wr(a_force($urandom % W), $urandom & $urandom & $urandom);
        2: wr(0, ($urandom % 3 == 0) ? $urandom : (32'h1 << ($urandom % NCH)));
        3: wr(a_mdis(), ($urandom % 4 == 0) ? 32'h1 : 32'h0);
        4: wr(($urandom % 2) ? a_stat($urandom % W) : 24 * G + 12 + 4 * ($urandom % 4), $urandom);
        default: drive_src({$urandom & $urandom, $urandom & $urandom});
      endcase
      check_all();
    end

    // R8: reset in mid-run clears everything
    @(negedge clk) rst_n = 1'b0;
    model_reset();
    @(negedge clk) rst_n = 1'b1;
    check_all();
    chk("R8 chan after second reset", 32'(chan_irq), 32'h0);

    finish_run();
  end
endmodule